// File: doc/BRIEF.md
# Folded Second-Order Recursive Filter (Folding Factor 4)

This block computes a second-order recursive filter on a stream of signed fixed-point samples. The filter does not have one adder and one multiplier per operation. Its four additions share one adder with a single pipeline stage, and its four coefficient multiplications share one multiplier with two pipeline stages. Each sample period is four clock cycles long. In every cycle the adder and the multiplier each run one operation, chosen by a 2-bit partition counter. A set of operand multiplexers sits in front of each unit. Every internal dependence is carried through a tap on a shared register chain. The tap depth is the register count for that edge: folding factor times edge delay, minus source latency, plus destination partition, minus source partition.

The filter keeps an internal state sequence w. Each new sample x(n) is added to two weighted feedback terms: w(n) = x(n) + fb1·w(n-1) + fb2·w(n-2). The output is taken from the stored state one period later: y(n) = w(n-1) + ff1·w(n-2) + ff2·w(n-3). The four coefficients are inputs. They are held constant while the filter runs and are changed only across a reset. A sample is offered with a strobe in the first cycle of a period. If no strobe arrives there, the whole datapath waits in place, so samples may come at any spacing of four cycles or more.

Top module: `biquad_fold4`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, res_valid_o is 0 and res_data_o is 0. All filter state starts at zero.
- R2: When smp_valid_i is high in partition 0, smp_data_i is taken as the next sample x(n). The partition counter then steps through 1, 2 and 3 on the following three cycles.
- R3: smp_valid_i and smp_data_i are ignored in partitions 1, 2 and 3. A strobe there neither starts a period nor changes a result.
- R4: In partition 0 with no strobe, the block holds. res_valid_o stays 0, res_data_o keeps its value, no state changes, and later results are the same as with no gap.
- R5: res_valid_o is high for exactly one cycle per accepted sample. That cycle is the third cycle after the cycle in which the strobe was accepted, which is partition 3 of the same period.
- R6: The recursion is w(n) = x(n) + fb1·w(n-1) + fb2·w(n-2). With ff1 = ff2 = 0 the output is y(n) = w(n-1).
- R7: The result published in period n is y(n) = w(n-1) + ff1·w(n-2) + ff2·w(n-3). A sample x(n) first affects the result of period n+1.
- R8: Data are DW-bit two's complement and coefficients are CW-bit two's complement with FRAC fractional bits (default 16, 16, 14). Each product is formed at full width, shifted right arithmetically by FRAC (rounding toward minus infinity), and cut to its low DW bits. Every sum wraps modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe, effective only in partition 0 |
| smp_data_i | input | DW | Input sample, signed |
| coef_fb1_i | input | CW | Feedback weight on w(n-1) |
| coef_fb2_i | input | CW | Feedback weight on w(n-2) |
| coef_ff1_i | input | CW | Feedforward weight on w(n-2) |
| coef_ff2_i | input | CW | Feedforward weight on w(n-3) |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_data_o | output | DW | Filter output y(n), signed |

## Verification
Three events can share partition 3: result publication, the counter wrapping back to partition 0, and a strobe that must be ignored. Some periods have spurious strobes with altered data in partitions 1 to 3, and the strobe in partition 3 lands in the same cycle as the result pulse. The test then checks that the pulse still lasts one cycle and that the result matches the arithmetic model. A hold gap in partition 0 can follow a published result at once. During the gap the result must stay frozen, and the recursion must resume with no drift. The bench checks this against the model over sweeps with impulse, step, alternating and pseudo-random inputs, using benign, zero, wrapping and extreme coefficient sets.

// File: rtl/biquad_fold_pkg.sv
package biquad_fold_pkg;

  typedef logic [1:0] part_t;

  localparam int FOLD    = 4;
  localparam int ADD_LAT = 1;
  localparam int MUL_LAT = 2;

  // adder partitions: stage-2 sum, output sum, feedback sum, input sum
  localparam part_t SLOT_A4 = 2'd0;
  localparam part_t SLOT_A2 = 2'd1;
  localparam part_t SLOT_A3 = 2'd2;
  localparam part_t SLOT_A1 = 2'd3;

  // multiplier partitions: fb1, ff2, ff1, fb2
  localparam part_t SLOT_M_FB1 = 2'd0;
  localparam part_t SLOT_M_FF2 = 2'd1;
  localparam part_t SLOT_M_FF1 = 2'd2;
  localparam part_t SLOT_M_FB2 = 2'd3;

  // registers on folded edge: N*w - P_src + v - u
  function automatic int fold_regs(int w, int lat, int u, int v);
    return FOLD * w - lat + v - u;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/biquad_fold_seq.sv
module biquad_fold_seq
  import biquad_fold_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  output part_t part_o,
  output logic  en_o,
  output logic  start_o
);

  part_t part_q;

  assign start_o = strobe_i && (part_q == part_t'(0));
  assign en_o    = strobe_i || (part_q != part_t'(0));
  assign part_o  = part_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   part_q <= part_t'(0);
    else if (en_o) part_q <= part_q + 2'd1;
  end

endmodule

// File: rtl/fold_pipe.sv
module fold_pipe #(
  parameter int W   = 16,
  parameter int LAT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar k = 0; k < LAT; k++) begin : g_st
    logic [W-1:0] q;
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= g_st[k-1].q;
      end
    end
  end

  assign q_o = g_st[LAT-1].q;

endmodule

// File: rtl/fold_tap_line.sv
module fold_tap_line #(
  parameter int W     = 16,
  parameter int DEPTH = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [W-1:0]           d_i,
  output logic [DEPTH:0][W-1:0]  taps_o
);

  assign taps_o[0] = d_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_st
    logic [W-1:0] q;
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= g_st[k-1].q;
      end
    end
    assign taps_o[k+1] = q;
  end

endmodule

// File: rtl/fold_units.sv
module fold_adder #(
  parameter int DW  = 16,
  parameter int LAT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o
);

  logic [DW-1:0] sum;
  assign sum = a_i + b_i;  // wraps modulo 2^DW

  fold_pipe #(.W(DW), .LAT(LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (sum),
    .q_o   (sum_o)
  );

endmodule

module fold_mult #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int LAT  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] c_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] prod_o
);

  localparam int PW = CW + DW;

  logic signed [PW-1:0] prod;
  logic        [DW-1:0] scaled;

  assign prod   = $signed(c_i) * $signed(d_i);
  assign scaled = DW'(prod >>> FRAC);  // floor shift, then truncate

  fold_pipe #(.W(DW), .LAT(LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (scaled),
    .q_o   (prod_o)
  );

endmodule

// File: rtl/biquad_fold4.sv
module biquad_fold4
  import biquad_fold_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic [CW-1:0] coef_fb1_i,
  input  logic [CW-1:0] coef_fb2_i,
  input  logic [CW-1:0] coef_ff1_i,
  input  logic [CW-1:0] coef_ff2_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o
);

  // edge register counts from the folding equation
  localparam int D_A1_A2  = fold_regs(1, ADD_LAT, int'(SLOT_A1), int'(SLOT_A2));
  localparam int D_A1_FB1 = fold_regs(1, ADD_LAT, int'(SLOT_A1), int'(SLOT_M_FB1));
  localparam int D_A1_FF1 = fold_regs(1, ADD_LAT, int'(SLOT_A1), int'(SLOT_M_FF1));
  localparam int D_A1_FB2 = fold_regs(1, ADD_LAT, int'(SLOT_A1), int'(SLOT_M_FB2));
  localparam int D_A1_FF2 = fold_regs(2, ADD_LAT, int'(SLOT_A1), int'(SLOT_M_FF2));
  localparam int D_A3_A1  = fold_regs(0, ADD_LAT, int'(SLOT_A3), int'(SLOT_A1));
  localparam int D_A4_A2  = fold_regs(0, ADD_LAT, int'(SLOT_A4), int'(SLOT_A2));
  localparam int D_FB1_A3 = fold_regs(0, MUL_LAT, int'(SLOT_M_FB1), int'(SLOT_A3));
  localparam int D_FF1_A4 = fold_regs(1, MUL_LAT, int'(SLOT_M_FF1), int'(SLOT_A4));
  localparam int D_FB2_A3 = fold_regs(1, MUL_LAT, int'(SLOT_M_FB2), int'(SLOT_A3));
  localparam int D_FF2_A4 = fold_regs(1, MUL_LAT, int'(SLOT_M_FF2), int'(SLOT_A4));

  localparam int A_DEPTH = imax(imax(imax(D_A1_A2, D_A1_FB1), imax(D_A1_FF1, D_A1_FB2)),
                                imax(imax(D_A1_FF2, D_A3_A1), D_A4_A2));
  localparam int M_DEPTH = imax(imax(D_FB1_A3, D_FF1_A4), imax(D_FB2_A3, D_FF2_A4));

  localparam part_t OUT_PART = part_t'((int'(SLOT_A2) + ADD_LAT) % FOLD);

  part_t part;
  logic  en, start;

  logic [DW-1:0] add_a, add_b, add_q;
  logic [CW-1:0] mul_c;
  logic [DW-1:0] mul_d, mul_q;
  logic [A_DEPTH:0][DW-1:0] a_taps;
  logic [M_DEPTH:0][DW-1:0] m_taps;
  logic [DW-1:0] x_q, y_q;
  logic          vld_q;

  biquad_fold_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(smp_valid_i),
    .part_o  (part),
    .en_o    (en),
    .start_o (start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    x_q <= '0;
    else if (start) x_q <= smp_data_i;
  end

  // adder operand select
  always_comb begin
    add_a = '0;
    add_b = '0;
    unique case (part)
      SLOT_A4: begin add_a = m_taps[D_FF1_A4]; add_b = m_taps[D_FF2_A4]; end
      SLOT_A2: begin add_a = a_taps[D_A1_A2];  add_b = a_taps[D_A4_A2];  end
      SLOT_A3: begin add_a = m_taps[D_FB1_A3]; add_b = m_taps[D_FB2_A3]; end
      SLOT_A1: begin add_a = x_q;              add_b = a_taps[D_A3_A1];  end
      default: ;
    endcase
  end

  // multiplier operand select
  always_comb begin
    mul_c = '0;
    mul_d = '0;
    unique case (part)
      SLOT_M_FB1: begin mul_c = coef_fb1_i; mul_d = a_taps[D_A1_FB1]; end
      SLOT_M_FF2: begin mul_c = coef_ff2_i; mul_d = a_taps[D_A1_FF2]; end
      SLOT_M_FF1: begin mul_c = coef_ff1_i; mul_d = a_taps[D_A1_FF1]; end
      SLOT_M_FB2: begin mul_c = coef_fb2_i; mul_d = a_taps[D_A1_FB2]; end
      default: ;
    endcase
  end

  fold_adder #(.DW(DW), .LAT(ADD_LAT)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (add_q)
  );

  fold_mult #(.DW(DW), .CW(CW), .FRAC(FRAC), .LAT(MUL_LAT)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .c_i   (mul_c),
    .d_i   (mul_d),
    .prod_o(mul_q)
  );

  fold_tap_line #(.W(DW), .DEPTH(A_DEPTH)) u_add_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .d_i   (add_q),
    .taps_o(a_taps)
  );

  fold_tap_line #(.W(DW), .DEPTH(M_DEPTH)) u_mul_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .d_i   (mul_q),
    .taps_o(m_taps)
  );

  // output sum is ready one adder latency after its partition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en && (part == OUT_PART);
      if (en && (part == OUT_PART)) y_q <= add_q;
    end
  end

  assign res_valid_o = vld_q;
  assign res_data_o  = y_q;

endmodule

// File: rtl/biquad_fold4_chk.sv
module biquad_fold4_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [1:0]    part_i,
  input logic          out_valid_i,
  input logic [DW-1:0] out_data_i
);

  // R1: cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_i && out_data_i == '0 && part_i == 2'd0));

  // R2: accepted strobe opens a period
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'd0 && in_valid_i) |=> (part_i == 2'd1));

  // R3: mid-period cycles advance regardless of the strobe
  a_r3_mid_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i != 2'd0) |=> (part_i == $past(part_i) + 2'd1));

  // R4: no strobe in partition 0 holds everything
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'd0 && !in_valid_i) |=>
      (part_i == 2'd0 && !out_valid_i && $stable(out_data_i)));

  // R5: single pulse, only in the last partition
  a_r5_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |=> !out_valid_i);

  a_r5_valid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (part_i == 2'd3));

  a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'd2) |=> out_valid_i);

  // R7: result changes only with its pulse
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_i |-> $stable(out_data_i));

endmodule

bind biquad_fold4 biquad_fold4_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (smp_valid_i),
  .part_i     (part),
  .out_valid_i(res_valid_o),
  .out_data_i (res_data_o)
);

// File: tb/biquad_fold4_test.sv
`timescale 1ns/1ps
module biquad_fold4_test;

  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int FRAC = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] fb1 = '0, fb2 = '0, ff1 = '0, ff2 = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [DW-1:0] w1, w2, w3, last_y;
  logic [15:0]   lfsr = 16'hace1;

  always #4 clk = ~clk;

  biquad_fold4 #(.DW(DW), .CW(CW), .FRAC(FRAC)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .smp_valid_i(in_valid),
    .smp_data_i (in_data),
    .coef_fb1_i (fb1),
    .coef_fb2_i (fb2),
    .coef_ff1_i (ff1),
    .coef_ff2_i (ff2),
    .res_valid_o(out_valid),
    .res_data_o (out_data)
  );

  // R8: full product, floor shift by FRAC, keep low DW bits
  function automatic logic [DW-1:0] qmul(logic [CW-1:0] c, logic [DW-1:0] d);
    longint p;
    p = longint'($signed(c)) * longint'($signed(d));
    p = p >>> FRAC;
    return p[DW-1:0];
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, $signed(act), $signed(exp));
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset(int set);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    case (set)
      0: begin fb1 = 16'd8192;  fb2 = -16'sd4096; ff1 = 16'd12288;   ff2 = -16'sd8192; end
      1: begin fb1 = 16'd0;     fb2 = 16'd0;      ff1 = 16'd0;       ff2 = 16'd0;      end
      2: begin fb1 = 16'd24576; fb2 = 16'd16384;  ff1 = 16'd0;       ff2 = 16'd0;      end
      default: begin fb1 = -16'sd16384; fb2 = -16'sd8192; ff1 = 16'h8000; ff2 = 16'h7fff; end
    endcase
    repeat (2) @(negedge clk);
    chk("R1", "valid in reset", {15'd0, out_valid}, 16'd0);
    chk("R1", "data in reset", out_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", {15'd0, out_valid}, 16'd0);
    chk("R1", "data after reset", out_data, 16'd0);
    w1 = '0; w2 = '0; w3 = '0; last_y = '0;
  endtask

  // one sample period, starting at a negedge in partition 0
  task automatic push(logic [DW-1:0] x, int gap, bit stray, string tag);
    logic [DW-1:0] exp_y, w_new;
    exp_y = w1 + qmul(ff1, w2) + qmul(ff2, w3);   // R7
    w_new = x + qmul(fb1, w1) + qmul(fb2, w2);    // R6
    w3 = w2; w2 = w1; w1 = w_new;
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0;
      in_data  = ~x;
      chk("R4", "valid in gap", {15'd0, out_valid}, 16'd0);
      chk("R4", "data in gap", out_data, last_y);
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = x;
    chk("R5", "valid at accept", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    for (int p = 1; p <= 2; p++) begin
      in_valid = stray;                 // R3: must be ignored
      in_data  = x ^ 16'h5a5a;
      chk("R5", "valid mid period", {15'd0, out_valid}, 16'd0);
      @(negedge clk);
    end
    in_valid = stray;
    in_data  = 16'h7fff;
    chk("R5", "valid pulse", {15'd0, out_valid}, 16'd1);
    chk(tag, "result", out_data, exp_y);
    @(negedge clk);
    in_valid = 1'b0;
    last_y   = exp_y;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    for (int set = 0; set < 4; set++) begin
      string tag;
      do_reset(set);
      case (set)
        0: tag = "R7";
        1: tag = "R2";
        2: tag = "R6";
        default: tag = "R8";
      endcase
      for (int i = 0; i < 48; i++) begin
        logic [DW-1:0] x;
        int  gap;
        bit  stray;
        if (i < 6)       x = (i == 0) ? 16'h2000 : 16'h0000;
        else if (i < 12) x = 16'h1000;
        else if (i < 18) x = (i % 2 == 1) ? 16'hd000 : 16'h3000;
        else             x = lfsr;
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gap   = (i % 5 == 4) ? (i % 3) + 1 : 0;
        stray = (i % 7 == 3);
        push(x, gap, stray, stray ? "R3" : tag);
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule